// File: doc/BRIEF.md
# Token Card Command Permission Gate

This block sits between the serial command decoder of a prepaid token card and its bit-addressed non-volatile store. For every command strobe it looks at the current bit address, the card's two lifecycle bits, the user-area lock bit, the chip-ID fuse, and two facts supplied by the counter logic: whether the addressed digit still holds a nonzero value, and whether the previous write succeeded. From these it decides whether a write-type command may proceed. A write-type command that is not permitted is not flagged as an error. It is handed on as a plain read, and it still leaves the bit address where it was.

The block also verifies the 64-bit transport secret. While the card is still with its issuer, the host clocks the secret in one bit at a time over the key region of the map. The block compares each incoming bit with the stored bit and raises a match flag only after a complete and clean pass. The match flag unlocks the issuer-side writes. Reads anywhere in the key region are reported as forced to one, so the secret is never driven out.

Top module: `card_access_ctrl`

## Requirements
- R1: The lifecycle code is issuer when pc0=0 and pc1=1, and user when pc0=1 and pc1=0. With any other pair, the only write that is granted is a bit-program in the configuration bits (addresses 104 to 107). Every erase and every extended command is refused.
- R2: Command codes on `cmd_kind` and `exec_kind` are read=0, putbit=1, program=2, erase=3, extended=4, reset=5. A refused program, erase or extended command appears on `exec_kind` as read=0 with `refused`=1. A granted one appears unchanged with `refused`=0. `advance` is 1 only for read and putbit.
- R3: In issuer mode, a program in the serial (24 to 63), configuration or key (148 to 211) bits is granted only once `tc_match` is 1. A program in a digit (64 to 103) additionally needs `digit_nz`=1.
- R4: In issuer mode, a program in the chip-ID bits (0 to 23) needs `tc_match`=1 and `fuse_blown`=0. In user mode, every write to the chip-ID and serial bits is refused.
- R5: In the user area (108 to 147), every write is granted in issuer mode. In user mode, a write there is granted only while `lock0` is 1.
- R6: In the upper digits (64 to 95), erase needs `prev_prog_ok`=1 and extended needs `digit_nz`=1. In issuer mode both also need `tc_match`. In the lowest digit (96 to 103), erase and extended are always refused.
- R7: In user mode, a program in the configuration bits is granted and an erase there is refused. Every write to the key bits is refused.
- R8: `read_high` is 1 exactly when a strobed command runs as a read at an address in 148 to 211.
- R9: `tc_match` rises on the clock after the putbit at address 211. This happens only if 64 consecutive putbits from address 148 have all equalled `key_bit`. A pass with any differing bit leaves it at 0.
- R10: `tc_match` clears on the clock after a reset command, and on the clock after the lifecycle code stops being issuer.
- R11: Every write to addresses 212 and above is refused in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_kind | input | 3 | Requested command code |
| addr | input | 9 | Current bit address |
| pc0 | input | 1 | First lifecycle bit |
| pc1 | input | 1 | Second lifecycle bit |
| lock0 | input | 1 | User-area unlocked when 1 |
| fuse_blown | input | 1 | Chip-ID fuse state |
| digit_nz | input | 1 | Addressed digit is nonzero |
| prev_prog_ok | input | 1 | Previous command was a successful program |
| put_data | input | 1 | Bit presented by a putbit |
| key_bit | input | 1 | Stored bit at the current address |
| exec_kind | output | 3 | Command to execute |
| refused | output | 1 | Write was degraded to a read |
| advance | output | 1 | Bit address counter steps |
| read_high | output | 1 | Read data must be forced to one |
| tc_match | output | 1 | Transport secret verified |

## Verification
Most of the visible state in this block is the transport match flag. A wrong match flag shows up within the same cycle as a grant or refusal in the serial, configuration or key bits while the card is in issuer mode. A wrong mismatch latch or bit counter shows no symptom until the putbit at address 211. At that point `tc_match` comes out wrong on the following clock. For that reason the bench runs one full clean pass and one pass with a single corrupted bit. Errors in the permission table are combinational, so they appear on `exec_kind` and `refused` in the same cycle the command is strobed.

// File: rtl/card_acc_pkg.sv
package card_acc_pkg;

    localparam int ADDR_W  = 9;
    localparam int SER_LO  = 24;
    localparam int DIG_LO  = 64;
    localparam int D0_LO   = 96;
    localparam int CFG_LO  = 104;
    localparam int USR_LO  = 108;
    localparam int KEY_LO  = 148;
    localparam int KEY_HI  = 211;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_PUT   = 3'd1,
        CMD_PROG  = 3'd2,
        CMD_ERASE = 3'd3,
        CMD_EXT   = 3'd4,
        CMD_RESET = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        F_CID, F_SER, F_DIG, F_D0, F_CFG, F_USER, F_KEY, F_NONE
    } field_e;

    typedef enum logic [1:0] {
        MODE_ISSUER, MODE_USER, MODE_NONE
    } mode_e;

    typedef struct packed {
        logic prog;
        logic erase;
        logic ext;
    } perm_t;

    function automatic mode_e mode_of(input logic b0, input logic b1);
        if (!b0 && b1)      return MODE_ISSUER;
        else if (b0 && !b1) return MODE_USER;
        else                return MODE_NONE;
    endfunction

    function automatic logic is_write(input cmd_e c);
        return (c == CMD_PROG) || (c == CMD_ERASE) || (c == CMD_EXT);
    endfunction

endpackage

// File: rtl/card_field_decode.sv
module card_field_decode
    import card_acc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output field_e        field
);
    logic [31:0] a;
    assign a = 32'(addr);

    always_comb begin
        if (a < 32'(SER_LO))       field = F_CID;
        else if (a < 32'(DIG_LO))  field = F_SER;
        else if (a < 32'(D0_LO))   field = F_DIG;
        else if (a < 32'(CFG_LO))  field = F_D0;
        else if (a < 32'(USR_LO))  field = F_CFG;
        else if (a < 32'(KEY_LO))  field = F_USER;
        else if (a <= 32'(KEY_HI)) field = F_KEY;
        else                       field = F_NONE;
    end
endmodule

// File: rtl/card_perm_table.sv
module card_perm_table
    import card_acc_pkg::*;
(
    input  mode_e  mode,
    input  field_e field,
    input  logic   tc_ok,
    input  logic   fuse_blown,
    input  logic   lock0,
    input  logic   digit_nz,
    input  logic   prev_prog_ok,
    output perm_t  perm
);
    always_comb begin
        perm = '0;
        unique case (mode)
            MODE_ISSUER: begin
                case (field)
                    F_CID:  perm.prog = tc_ok && !fuse_blown;
                    F_SER:  begin perm.prog = tc_ok; perm.ext = tc_ok; end
                    F_DIG:  begin
                        perm.prog  = tc_ok && digit_nz;
                        perm.erase = tc_ok && prev_prog_ok;
                        perm.ext   = tc_ok && digit_nz;
                    end
                    F_D0:   perm.prog = tc_ok && digit_nz;
                    F_CFG:  perm.prog = tc_ok;
                    F_USER: perm = '{prog: 1'b1, erase: 1'b1, ext: 1'b1};
                    F_KEY:  perm = '{prog: tc_ok, erase: tc_ok, ext: tc_ok};
                    default: perm = '0;
                endcase
            end
            MODE_USER: begin
                case (field)
                    F_DIG:  begin
                        perm.prog  = digit_nz;
                        perm.erase = prev_prog_ok;
                        perm.ext   = digit_nz;
                    end
                    F_D0:   perm.prog = digit_nz;
                    F_CFG:  perm.prog = 1'b1;
                    F_USER: perm = '{prog: lock0, erase: lock0, ext: lock0};
                    default: perm = '0;
                endcase
            end
            default: perm.prog = (field == F_CFG);
        endcase
    end
endmodule

// File: rtl/card_tc_verify.sv
module card_tc_verify
    import card_acc_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int CODE_LO = KEY_LO,
    parameter int CODE_HI = KEY_HI
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          issuer,
    input  logic          put_en,
    input  logic [AW-1:0] addr,
    input  logic          din,
    input  logic          stored,
    output logic          match
);
    localparam int CODE_BITS = CODE_HI - CODE_LO + 1;
    localparam int CNT_W     = $clog2(CODE_BITS + 1);

    logic             mism, mism_n, diff, first, last;
    logic [CNT_W-1:0] cnt, cnt_n;

    assign diff  = din ^ stored;
    assign first = (32'(addr) == 32'(CODE_LO));
    assign last  = (32'(addr) == 32'(CODE_HI));

    always_comb begin
        if (first) begin
            mism_n = diff;
            cnt_n  = CNT_W'(1);
        end else begin
            mism_n = mism | diff;
            cnt_n  = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !issuer) begin
            match <= 1'b0;
            mism  <= 1'b0;
            cnt   <= '0;
        end else if (put_en) begin
            mism <= mism_n;
            cnt  <= cnt_n;
            if (last && !mism_n && cnt_n == CNT_W'(CODE_BITS))
                match <= 1'b1;
        end
    end

    // R9: the flag only rises right after the final secret bit is entered
    a_r9_rise_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(match) |-> $past(put_en && last));

    // R10: a reset command clears the flag on the next clock
    a_r10_clear_on_reset_cmd: assert property (@(posedge clk) disable iff (rst)
        clr |=> !match);

    // R10: leaving issuer mode clears the flag on the next clock
    a_r10_clear_out_of_issuer: assert property (@(posedge clk) disable iff (rst)
        !issuer |=> !match);
endmodule

// File: rtl/card_access_ctrl.sv
module card_access_ctrl
    import card_acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_kind,
    input  logic [8:0] addr,
    input  logic       pc0,
    input  logic       pc1,
    input  logic       lock0,
    input  logic       fuse_blown,
    input  logic       digit_nz,
    input  logic       prev_prog_ok,
    input  logic       put_data,
    input  logic       key_bit,
    output logic [2:0] exec_kind,
    output logic       refused,
    output logic       advance,
    output logic       read_high,
    output logic       tc_match
);
    cmd_e   cmd;
    field_e field;
    mode_e  mode;
    perm_t  perm;
    logic   allowed, put_en, clr;
    cmd_e   exec;

    assign cmd  = cmd_e'(cmd_kind);
    assign mode = mode_of(pc0, pc1);

    card_field_decode #(.AW(ADDR_W)) u_dec (
        .addr  (addr),
        .field (field)
    );

    card_perm_table u_perm (
        .mode         (mode),
        .field        (field),
        .tc_ok        (tc_match),
        .fuse_blown   (fuse_blown),
        .lock0        (lock0),
        .digit_nz     (digit_nz),
        .prev_prog_ok (prev_prog_ok),
        .perm         (perm)
    );

    assign put_en = cmd_valid && (cmd == CMD_PUT) && (mode == MODE_ISSUER) && (field == F_KEY);
    assign clr    = cmd_valid && (cmd == CMD_RESET);

    card_tc_verify #(.AW(ADDR_W), .CODE_LO(KEY_LO), .CODE_HI(KEY_HI)) u_tc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .issuer (mode == MODE_ISSUER),
        .put_en (put_en),
        .addr   (addr),
        .din    (put_data),
        .stored (key_bit),
        .match  (tc_match)
    );

    always_comb begin
        case (cmd)
            CMD_PROG:  allowed = perm.prog;
            CMD_ERASE: allowed = perm.erase;
            CMD_EXT:   allowed = perm.ext;
            default:   allowed = 1'b1;
        endcase
        exec = allowed ? cmd : CMD_READ;
    end

    assign exec_kind = exec;
    assign refused   = cmd_valid && !allowed;
    assign advance   = cmd_valid && (cmd == CMD_READ || cmd == CMD_PUT);
    assign read_high = cmd_valid && (exec == CMD_READ) && (field == F_KEY);

    // R2: a degraded write always executes as a read
    a_r2_refused_is_read: assert property (@(posedge clk) disable iff (rst)
        refused |-> exec_kind == 3'd0);

    // R2: write-type requests never move the address counter
    a_r2_write_holds_addr: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind inside {3'd2, 3'd3, 3'd4}) |-> !advance);

    // R1: with no valid lifecycle code only configuration-bit writes pass
    a_r1_none_mode_cfg_only: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && pc0 == pc1 && exec_kind inside {3'd2, 3'd3, 3'd4})
            |-> (exec_kind == 3'd2 && addr >= 9'd104 && addr <= 9'd107));

    // R11: nothing past the key region may be written
    a_r11_tail_locked: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && addr > 9'd211 && cmd_kind inside {3'd2, 3'd3, 3'd4}) |-> refused);
endmodule

// File: tb/card_access_ctrl_tb.sv
module card_access_ctrl_tb;
    localparam logic [2:0] RD = 3'd0, PUT = 3'd1, PRG = 3'd2, ERS = 3'd3, EXT = 3'd4, RSTC = 3'd5;
    localparam logic [63:0] CODE = 64'hA5C3_1E7F_0429_B6D8;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0;
    logic [2:0] cmd_kind = RD;
    logic [8:0] addr = '0;
    logic pc0 = 0, pc1 = 1, lock0 = 1, fuse_blown = 0, digit_nz = 1, prev_prog_ok = 1;
    logic put_data = 0, key_bit = 0;
    logic [2:0] exec_kind;
    logic refused, advance, read_high, tc_match;
    int total = 0, bad = 0, cycles = 0;

    always #5 clk = ~clk;

    card_access_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .addr(addr),
        .pc0(pc0), .pc1(pc1), .lock0(lock0), .fuse_blown(fuse_blown), .digit_nz(digit_nz),
        .prev_prog_ok(prev_prog_ok), .put_data(put_data), .key_bit(key_bit),
        .exec_kind(exec_kind), .refused(refused), .advance(advance),
        .read_high(read_high), .tc_match(tc_match)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // strobe one command at a negedge and check the combinational decision
    task automatic try_cmd(input string req, input logic [2:0] k, input int a, input bit grant);
        @(negedge clk);
        cmd_valid = 1; cmd_kind = k; addr = 9'(a);
        #1;
        chk(req, int'(exec_kind), grant ? int'(k) : int'(RD));
        chk(req, int'(refused), grant ? 0 : 1);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic enter_code(input bit corrupt);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            cmd_valid = 1; cmd_kind = PUT; addr = 9'(148 + i);
            key_bit = CODE[i];
            put_data = CODE[i] ^ (corrupt && i == 37);
        end
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic t_reset_state;
        chk("R9 reset tc_match", int'(tc_match), 0);
    endtask

    task automatic t_none_mode;
        pc0 = 1; pc1 = 1;
        try_cmd("R1 none prog cfg", PRG, 104, 1);
        try_cmd("R1 none prog user", PRG, 110, 0);
        try_cmd("R1 none erase cfg", ERS, 105, 0);
        pc0 = 0; pc1 = 0;
        try_cmd("R1 none ext digit", EXT, 70, 0);
        pc0 = 0; pc1 = 1;
    endtask

    task automatic t_advance;
        @(negedge clk); cmd_valid = 1; cmd_kind = RD; addr = 9'd10; #1;
        chk("R2 read advances", int'(advance), 1);
        cmd_kind = PUT; #1;
        chk("R2 putbit advances", int'(advance), 1);
        cmd_kind = PRG; addr = 9'd120; #1;
        chk("R2 granted prog holds", int'(advance), 0);
        chk("R2 granted prog kind", int'(exec_kind), int'(PRG));
        cmd_kind = PRG; addr = 9'd30; #1;
        chk("R2 refused prog holds", int'(advance), 0);
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic t_issuer_locked;
        try_cmd("R3 ser needs tc", PRG, 30, 0);
        try_cmd("R3 cfg needs tc", PRG, 104, 0);
        try_cmd("R3 key needs tc", PRG, 150, 0);
        try_cmd("R3 digit needs tc", PRG, 70, 0);
        try_cmd("R5 issuer user prog", PRG, 120, 1);
        try_cmd("R5 issuer user erase", ERS, 130, 1);
    endtask

    task automatic t_code_bad;
        enter_code(1);
        chk("R9 corrupted pass", int'(tc_match), 0);
    endtask

    task automatic t_code_good;
        enter_code(0);
        chk("R9 clean pass", int'(tc_match), 1);
    endtask

    task automatic t_issuer_open;
        try_cmd("R3 ser prog", PRG, 30, 1);
        try_cmd("R3 cfg prog", PRG, 105, 1);
        fuse_blown = 0; try_cmd("R4 cid fuse intact", PRG, 5, 1);
        fuse_blown = 1; try_cmd("R4 cid fuse blown", PRG, 5, 0);
        fuse_blown = 0;
        digit_nz = 0; try_cmd("R3 digit zero", PRG, 70, 0);
        digit_nz = 1; try_cmd("R3 digit nonzero", PRG, 70, 1);
        prev_prog_ok = 1; try_cmd("R6 erase after prog", ERS, 64, 1);
        prev_prog_ok = 0; try_cmd("R6 erase no prog", ERS, 70, 0);
        prev_prog_ok = 1;
        try_cmd("R6 d0 erase", ERS, 100, 0);
        try_cmd("R6 d0 ext", EXT, 98, 0);
        try_cmd("R3 key erase", ERS, 150, 1);
        try_cmd("R11 tail prog", PRG, 230, 0);
    endtask

    task automatic t_key_read;
        @(negedge clk); cmd_valid = 1; cmd_kind = RD; addr = 9'd160; #1;
        chk("R8 key read high", int'(read_high), 1);
        addr = 9'd211; #1;
        chk("R8 key last bit high", int'(read_high), 1);
        addr = 9'd120; #1;
        chk("R8 user read normal", int'(read_high), 0);
        addr = 9'd212; #1;
        chk("R8 tail read normal", int'(read_high), 0);
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic t_clear;
        @(negedge clk); cmd_valid = 1; cmd_kind = RSTC; addr = 9'd0;
        @(negedge clk); cmd_valid = 0;
        chk("R10 reset cmd clears", int'(tc_match), 0);
        enter_code(0);
        chk("R10 re-entry matches", int'(tc_match), 1);
        pc0 = 1; pc1 = 0;
        @(negedge clk);
        chk("R10 leave issuer clears", int'(tc_match), 0);
    endtask

    task automatic t_user_mode;
        try_cmd("R4 user cid", PRG, 5, 0);
        try_cmd("R4 user ser", PRG, 30, 0);
        lock0 = 1; try_cmd("R5 user unlocked prog", PRG, 120, 1);
        try_cmd("R5 user unlocked erase", ERS, 140, 1);
        lock0 = 0; try_cmd("R5 user locked prog", PRG, 120, 0);
        try_cmd("R5 user locked erase", ERS, 140, 0);
        lock0 = 1;
        try_cmd("R7 user cfg prog", PRG, 105, 1);
        try_cmd("R7 user cfg erase", ERS, 105, 0);
        try_cmd("R7 user key prog", PRG, 160, 0);
        digit_nz = 1; try_cmd("R6 user ext digit", EXT, 70, 1);
        digit_nz = 0; try_cmd("R6 user ext zero digit", EXT, 70, 0);
        digit_nz = 1;
        try_cmd("R11 user tail erase", ERS, 250, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_none_mode();
        t_advance();
        t_issuer_locked();
        t_code_bad();
        t_code_good();
        t_issuer_open();
        t_key_read();
        t_clear();
        t_user_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule